// File: doc/BRIEF.md
# Zero-Latency Register Instruction Cache

This block sits in the fetch stage of a 32-bit in-order processor and holds recently fetched instruction words. Its tag, valid and data arrays are flip-flops, so a lookup is purely combinational. When the fetch address hits, the instruction word leaves the block in the same cycle the address arrives, and the fetch stage sees no extra latency. The price is area: 64 words of registers plus a wide read multiplexer.

The cache is direct-mapped. It holds 64 words in total, split into lines of a configurable length (8 words by default, which gives 8 lines). Each line has one tag and one valid bit. On a miss the block raises its stall output and acts as an AXI4 read master. It issues one incrementing burst that covers the whole line and stores each returned beat at the next word offset. The line becomes valid when the last beat arrives. A flush input invalidates every line in one clock. A sticky flag records any error response seen during a refill. The processor never writes through this block.

Top module: `zl_icache`

## Requirements
- R1: Synchronous active-low reset, or a one-cycle `flush`, clears every valid bit. The next fetch of any address therefore misses. After reset, `m_axi_arvalid`, `m_axi_rready` and `fill_error` are low.
- R2: When `fetch_req` is high and the addressed line is valid with a matching tag, `fetch_hit` is high and `fetch_stall` is low in that same cycle. `fetch_instr` then carries the stored word.
- R3: A fetch that misses raises `fetch_stall` in the same cycle. The block then issues exactly one read address with the address aligned to the line (bits [4:0] zero by default), `m_axi_arlen` = line words - 1 (7 by default), `m_axi_arburst` = 2'b01 (incrementing) and `m_axi_arsize` = 3'b010 (4 bytes).
- R4: Once `m_axi_arvalid` is high, it stays high and `m_axi_araddr` stays unchanged until `m_axi_arready` is seen.
- R5: The k-th accepted data beat of a refill is stored at word offset k of the line. After a clean refill, every word of that line hits and returns the memory contents.
- R6: The edge that accepts the beat with `m_axi_rlast` completes the refill. In the cycle right after that edge, `fetch_stall` is low and the requested word is served as a hit.
- R7: A non-zero `m_axi_rresp` on any beat sets `fill_error`. Only reset clears it. The refilled line stays invalid, so a later fetch of it misses again.
- R8: If `flush` is pulsed while a refill is in progress, the burst is drained, but the line is not marked valid.
- R9: The line index is address bits [7:5] and the tag is bits [31:8] (defaults). Two addresses with the same index and different tags evict each other.
- R10: At most one burst is outstanding. `m_axi_arvalid` is never high while beats of the current burst are still awaited, and `m_axi_rready` is high only in the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate every line |
| fetch_req | input | 1 | A fetch address is presented |
| fetch_addr | input | 32 | Byte address of the instruction |
| fetch_instr | output | 32 | Instruction word for the address |
| fetch_hit | output | 1 | Word is valid this cycle |
| fetch_stall | output | 1 | Fetch must wait (miss) |
| fill_error | output | 1 | Sticky refill error flag |
| m_axi_arvalid | output | 1 | Read address valid |
| m_axi_arready | input | 1 | Read address accepted |
| m_axi_araddr | output | 32 | Line-aligned burst address |
| m_axi_arlen | output | 8 | Beats minus one |
| m_axi_arsize | output | 3 | Bytes per beat, log2 |
| m_axi_arburst | output | 2 | Burst type (incrementing) |
| m_axi_rvalid | input | 1 | Read data valid |
| m_axi_rready | output | 1 | Read data accepted |
| m_axi_rdata | input | 32 | Read data beat |
| m_axi_rresp | input | 2 | Beat response, 0 = good |
| m_axi_rlast | input | 1 | Final beat of the burst |

## Verification
The assertions assume that the memory side returns exactly line-length beats for each address it accepts, and that it raises `m_axi_rlast` only on the final beat. They also assume that `fetch_req` and `fetch_addr` change only between clock edges. The bench's memory model follows these rules by counting beats per accepted address. It inserts random gaps in `m_axi_arready` and `m_axi_rvalid`, returns an error response only on lines that a directed test has chosen, and drives fetch and flush at the falling edge. Flush pulses are issued only while no fetch is pending, except in the directed test for flushing during a refill.

// File: rtl/zl_icache_pkg.sv
// Shared types and AXI constants for the register-based instruction cache.
// Assumes AXI4 encodings for burst type and response.
package zl_icache_pkg;
    typedef enum logic [1:0] {
        FILL_IDLE = 2'd0,
        FILL_ADDR = 2'd1,
        FILL_DATA = 2'd2
    } fill_state_e;

    localparam logic [1:0] AXI_BURST_INCR = 2'b01;
    localparam logic [1:0] AXI_RESP_OKAY  = 2'b00;
endpackage

// File: rtl/zl_tag_store.sv
// Per-line valid bit and tag, held in flip-flops, with a combinational lookup.
// Assumes that set and drop never target a line in the same cycle; clear_all wins.
module zl_tag_store #(
    parameter int LINES = 8,
    parameter int IDX_W = 3,
    parameter int TAG_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_all,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             drop_en,
    input  logic [IDX_W-1:0] drop_idx,
    input  logic [IDX_W-1:0] look_idx,
    input  logic [TAG_W-1:0] look_tag,
    output logic             look_hit
);
    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Update one line's valid bit and tag.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_all) begin
                valid_q[g] <= 1'b0;
            end else if (set_en && set_idx == IDX_W'(g)) begin
                valid_q[g] <= 1'b1;
                tag_q[g]   <= set_tag;
            end else if (drop_en && drop_idx == IDX_W'(g)) begin
                valid_q[g] <= 1'b0;
            end
        end
    end

    // Compare the addressed line against the fetch tag.
    always_comb begin
        look_hit = valid_q[look_idx] && (tag_q[look_idx] == look_tag);
    end
endmodule

// File: rtl/zl_data_store.sv
// Instruction word array in flip-flops: one synchronous write port and one
// combinational read port. Contents are unreset and are qualified by the valid bits.
module zl_data_store #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 3
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data
);
    localparam int ENTRIES = 1 << (IDX_W + OFF_W);

    logic [DATA_W-1:0] words_q [ENTRIES];

    // Store one refill beat.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            words_q[{wr_idx, wr_off}] <= wr_data;
        end
    end

    // Zero-latency read of the addressed word.
    always_comb begin
        rd_data = words_q[{rd_idx, rd_off}];
    end
endmodule

// File: rtl/zl_refill_ctrl.sv
// Line refill sequencer: one AXI4 INCR read burst per miss, with beats
// written in order. Assumes the slave returns exactly LINE_WORDS beats.
// A flush seen during the refill, or any error beat, keeps the line invalid.
module zl_refill_ctrl
    import zl_icache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 8,
    parameter int OFF_W      = 3,
    parameter int IDX_W      = 3,
    parameter int TAG_W      = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              miss_req,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              fill_start,
    output logic [IDX_W-1:0]  fill_idx,
    output logic [TAG_W-1:0]  fill_tag,
    output logic              wr_en,
    output logic [OFF_W-1:0]  wr_off,
    output logic [DATA_W-1:0] wr_data,
    output logic              line_done,
    output logic              err_flag,
    output logic              arvalid,
    input  logic              arready,
    output logic [ADDR_W-1:0] araddr,
    output logic [7:0]        arlen,
    output logic [2:0]        arsize,
    output logic [1:0]        arburst,
    input  logic              rvalid,
    output logic              rready,
    input  logic [DATA_W-1:0] rdata,
    input  logic [1:0]        rresp,
    input  logic              rlast
);
    localparam int LOW_W = OFF_W + $clog2(DATA_W / 8);

    fill_state_e       state_q;
    logic [ADDR_W-1:0] line_addr_q;
    logic [OFF_W-1:0]  beat_q;
    logic              burst_bad_q;
    logic              poison_q;
    logic              beat_take;

    // Decode the handshakes and the write strobes.
    always_comb begin
        fill_start = (state_q == FILL_IDLE) && miss_req;
        beat_take  = (state_q == FILL_DATA) && rvalid;
        wr_en      = beat_take;
        wr_off     = beat_q;
        wr_data    = rdata;
        line_done  = beat_take && rlast && !burst_bad_q && (rresp == AXI_RESP_OKAY)
                     && !poison_q && !flush;
        fill_idx   = line_addr_q[LOW_W +: IDX_W];
        fill_tag   = line_addr_q[ADDR_W-1 -: TAG_W];
        arvalid    = (state_q == FILL_ADDR);
        rready     = (state_q == FILL_DATA);
        araddr     = line_addr_q;
        arlen      = 8'(LINE_WORDS - 1);
        arsize     = 3'($clog2(DATA_W / 8));
        arburst    = AXI_BURST_INCR;
    end

    // Advance the refill sequence and its per-burst flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= FILL_IDLE;
            line_addr_q <= '0;
            beat_q      <= '0;
            burst_bad_q <= 1'b0;
            poison_q    <= 1'b0;
        end else begin
            case (state_q)
                FILL_IDLE: if (miss_req) begin
                    state_q     <= FILL_ADDR;
                    line_addr_q <= {miss_addr[ADDR_W-1:LOW_W], {LOW_W{1'b0}}};
                    burst_bad_q <= 1'b0;
                    poison_q    <= 1'b0;
                end
                FILL_ADDR: if (arready) begin
                    state_q <= FILL_DATA;
                    beat_q  <= '0;
                end
                FILL_DATA: if (rvalid) begin
                    beat_q <= beat_q + 1'b1;
                    if (rresp != AXI_RESP_OKAY) burst_bad_q <= 1'b1;
                    if (rlast) state_q <= FILL_IDLE;
                end
                default: state_q <= FILL_IDLE;
            endcase
            if (flush && state_q != FILL_IDLE) poison_q <= 1'b1;
        end
    end

    // Hold the sticky error flag until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
        end else if (beat_take && rresp != AXI_RESP_OKAY) begin
            err_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/zl_icache.sv
// Direct-mapped instruction cache with register storage: a hit is served
// combinationally in the cycle of the address. Assumes word-aligned fetches,
// LINE_WORDS >= 2 and at least two lines.
module zl_icache #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int TOTAL_WORDS = 64,
    parameter int LINE_WORDS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [DATA_W-1:0] fetch_instr,
    output logic              fetch_hit,
    output logic              fetch_stall,
    output logic              fill_error,
    output logic              m_axi_arvalid,
    input  logic              m_axi_arready,
    output logic [ADDR_W-1:0] m_axi_araddr,
    output logic [7:0]        m_axi_arlen,
    output logic [2:0]        m_axi_arsize,
    output logic [1:0]        m_axi_arburst,
    input  logic              m_axi_rvalid,
    output logic              m_axi_rready,
    input  logic [DATA_W-1:0] m_axi_rdata,
    input  logic [1:0]        m_axi_rresp,
    input  logic              m_axi_rlast
);
    localparam int LINES  = TOTAL_WORDS / LINE_WORDS;
    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int OFF_W  = $clog2(LINE_WORDS);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - BYTE_W - OFF_W - IDX_W;

    logic [OFF_W-1:0]  look_off;
    logic [IDX_W-1:0]  look_idx;
    logic [TAG_W-1:0]  look_tag;
    logic [BYTE_W-1:0] unused_byte_bits;
    logic              tag_hit;
    logic              fill_start;
    logic [IDX_W-1:0]  fill_idx;
    logic [TAG_W-1:0]  fill_tag;
    logic              wr_en;
    logic [OFF_W-1:0]  wr_off;
    logic [DATA_W-1:0] wr_data;
    logic              line_done;

    // Split the fetch address into offset, index and tag.
    always_comb begin
        unused_byte_bits = fetch_addr[BYTE_W-1:0];
        look_off         = fetch_addr[BYTE_W +: OFF_W];
        look_idx         = fetch_addr[BYTE_W + OFF_W +: IDX_W];
        look_tag         = fetch_addr[ADDR_W-1 -: TAG_W];
        fetch_hit        = fetch_req && tag_hit;
        fetch_stall      = fetch_req && !tag_hit;
    end

    zl_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_all(flush),
        .set_en   (line_done),
        .set_idx  (fill_idx),
        .set_tag  (fill_tag),
        .drop_en  (fill_start),
        .drop_idx (look_idx),
        .look_idx (look_idx),
        .look_tag (look_tag),
        .look_hit (tag_hit)
    );

    zl_data_store #(.DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_data (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_idx (fill_idx),
        .wr_off (wr_off),
        .wr_data(wr_data),
        .rd_idx (look_idx),
        .rd_off (look_off),
        .rd_data(fetch_instr)
    );

    zl_refill_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS),
        .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .miss_req  (fetch_stall),
        .miss_addr (fetch_addr),
        .fill_start(fill_start),
        .fill_idx  (fill_idx),
        .fill_tag  (fill_tag),
        .wr_en     (wr_en),
        .wr_off    (wr_off),
        .wr_data   (wr_data),
        .line_done (line_done),
        .err_flag  (fill_error),
        .arvalid   (m_axi_arvalid),
        .arready   (m_axi_arready),
        .araddr    (m_axi_araddr),
        .arlen     (m_axi_arlen),
        .arsize    (m_axi_arsize),
        .arburst   (m_axi_arburst),
        .rvalid    (m_axi_rvalid),
        .rready    (m_axi_rready),
        .rdata     (m_axi_rdata),
        .rresp     (m_axi_rresp),
        .rlast     (m_axi_rlast)
    );
endmodule

// File: rtl/zl_icache_chk.sv
// Temporal checks on the cache ports, bound into every zl_icache instance.
module zl_icache_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_WORDS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              fetch_hit,
    input logic              fetch_stall,
    input logic              fill_error,
    input logic              m_axi_arvalid,
    input logic              m_axi_arready,
    input logic [ADDR_W-1:0] m_axi_araddr,
    input logic [7:0]        m_axi_arlen,
    input logic [1:0]        m_axi_arburst,
    input logic              m_axi_rready
);
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !fetch_hit); // R1
    AST_HIT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hit |-> !fetch_stall); // R2
    AST_AR_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_axi_arvalid) |-> $past(fetch_stall)); // R3
    AST_AR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        m_axi_arvalid |-> (m_axi_arlen == 8'(LINE_WORDS - 1)) && (m_axi_arburst == 2'b01)); // R3
    AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_axi_arvalid && !m_axi_arready) |=> m_axi_arvalid && $stable(m_axi_araddr)); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fill_error |=> fill_error); // R7
    AST_ONE_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        m_axi_rready |-> !m_axi_arvalid); // R10
endmodule

bind zl_icache zl_icache_chk #(.ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .fetch_hit    (fetch_hit),
    .fetch_stall  (fetch_stall),
    .fill_error   (fill_error),
    .m_axi_arvalid(m_axi_arvalid),
    .m_axi_arready(m_axi_arready),
    .m_axi_araddr (m_axi_araddr),
    .m_axi_arlen  (m_axi_arlen),
    .m_axi_arburst(m_axi_arburst),
    .m_axi_rready (m_axi_rready)
);

// File: tb/sim_zl_icache.sv
`timescale 1ns/1ps
// Bench for zl_icache: a randomised AXI memory model, directed corner cases,
// and a reference model of valid/tag per line.
module sim_zl_icache;
    localparam int LW = 8;
    localparam int NL = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        fetch_req = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic [31:0] fetch_instr;
    logic        fetch_hit, fetch_stall, fill_error;
    logic        m_axi_arvalid;
    logic        m_axi_arready = 1'b0;
    logic [31:0] m_axi_araddr;
    logic [7:0]  m_axi_arlen;
    logic [2:0]  m_axi_arsize;
    logic [1:0]  m_axi_arburst;
    logic        m_axi_rvalid = 1'b0;
    logic        m_axi_rready;
    logic [31:0] m_axi_rdata = '0;
    logic [1:0]  m_axi_rresp = '0;
    logic        m_axi_rlast = 1'b0;

    always #2 clk = ~clk;

    zl_icache u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .fetch_instr(fetch_instr), .fetch_hit(fetch_hit),
        .fetch_stall(fetch_stall), .fill_error(fill_error),
        .m_axi_arvalid(m_axi_arvalid), .m_axi_arready(m_axi_arready),
        .m_axi_araddr(m_axi_araddr), .m_axi_arlen(m_axi_arlen),
        .m_axi_arsize(m_axi_arsize), .m_axi_arburst(m_axi_arburst),
        .m_axi_rvalid(m_axi_rvalid), .m_axi_rready(m_axi_rready),
        .m_axi_rdata(m_axi_rdata), .m_axi_rresp(m_axi_rresp), .m_axi_rlast(m_axi_rlast)
    );

    int checks = 0, failures = 0, cyc = 0;
    bit done = 1'b0;

    int last_done_cyc = -1, done_count = 0;
    bit s_busy = 1'b0, ar_pend = 1'b0, r_pend = 1'b0, prev_ar_wait = 1'b0;
    int s_beat = 0;
    logic [31:0] s_addr = '0, pend_addr = '0, prev_araddr = '0;
    bit err_en = 1'b0;
    logic [31:0] err_line = '0;
    int viol_r3 = 0, viol_r4 = 0, viol_r10 = 0;

    bit          mv [NL];
    logic [23:0] mt [NL];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h1357_9BDF;
    endfunction

    function automatic bit model_hit(input logic [31:0] a);
        return mv[a[7:5]] && (mt[a[7:5]] == a[31:8]);
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < NL; i++) mv[i] = 1'b0;
    endtask

    // AXI memory model: decides at each falling edge what the next rising edge sees.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                s_busy = 0; ar_pend = 0; r_pend = 0; prev_ar_wait = 0;
                m_axi_arready = 0; m_axi_rvalid = 0; m_axi_rlast = 0;
                continue;
            end
            if (prev_ar_wait && (!m_axi_arvalid || m_axi_araddr != prev_araddr)) viol_r4++;
            if (ar_pend) begin
                s_busy = 1; s_addr = pend_addr; s_beat = 0;
            end
            if (r_pend) begin
                if (s_beat == LW - 1) begin
                    s_busy = 0; done_count++; last_done_cyc = cyc;
                end
                s_beat++;
            end
            if (m_axi_arvalid && s_busy) viol_r10++;
            if (m_axi_rready && !s_busy) viol_r10++;
            if (m_axi_arvalid && (m_axi_arlen != 8'd7 || m_axi_arburst != 2'b01 ||
                                  m_axi_arsize != 3'b010 || m_axi_araddr[4:0] != 5'd0)) viol_r3++;
            m_axi_arready = !s_busy && ($urandom % 3 != 0);
            m_axi_rvalid  = s_busy && ($urandom % 4 != 0);
            m_axi_rdata   = mem_word(s_addr + 32'(4 * s_beat));
            m_axi_rlast   = s_busy && (s_beat == LW - 1);
            m_axi_rresp   = (err_en && s_addr == err_line && s_beat == 2) ? 2'b10 : 2'b00;
            ar_pend       = m_axi_arvalid && m_axi_arready;
            pend_addr     = m_axi_araddr;
            r_pend        = m_axi_rvalid && m_axi_rready;
            prev_ar_wait  = m_axi_arvalid && !m_axi_arready;
            prev_araddr   = m_axi_araddr;
        end
    end

    // One fetch from presentation to served word, checking hit/miss timing.
    task automatic do_fetch(input logic [31:0] a, input bit exp_hit, input string rq);
        int waitc = 0;
        @(negedge clk);
        fetch_req = 1; fetch_addr = a;
        #1;
        chk(fetch_hit === exp_hit, rq, "hit on presentation", 32'(fetch_hit), 32'(exp_hit));
        if (exp_hit) chk(fetch_stall === 1'b0, "R2", "stall on hit", 32'(fetch_stall), 0);
        else chk(fetch_stall === 1'b1, "R3", "stall on miss", 32'(fetch_stall), 1);
        while (fetch_stall === 1'b1 && waitc < 500) begin
            @(negedge clk); #1; waitc++;
        end
        if (!exp_hit) chk(last_done_cyc == cyc, "R6", "stall release cycle",
                          32'(last_done_cyc), 32'(cyc));
        chk(fetch_hit === 1'b1 && fetch_instr === mem_word(a), rq, "served word",
            fetch_instr, mem_word(a));
        mv[a[7:5]] = 1'b1; mt[a[7:5]] = a[31:8];
        fetch_req = 0;
    endtask

    task automatic pulse_flush();
        @(negedge clk); flush = 1;
        @(negedge clk); flush = 0;
        model_clear();
    endtask

    initial begin
        int d;
        void'($urandom(32'd4242));
        model_clear();
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        chk(m_axi_arvalid === 0 && m_axi_rready === 0 && fill_error === 0, "R1",
            "idle after reset", {m_axi_arvalid, m_axi_rready, fill_error}, 0);

        do_fetch(32'h40, 1'b0, "R1");
        for (int k = 0; k < LW; k++) do_fetch(32'h40 + 32'(4 * k), 1'b1, "R5");

        do_fetch(32'h140, 1'b0, "R9");
        do_fetch(32'h44, 1'b0, "R9");

        do_fetch(32'h48, 1'b1, "R2");
        pulse_flush();
        do_fetch(32'h48, 1'b0, "R1");

        // Flush while the refill is in its data phase.
        d = done_count;
        @(negedge clk); fetch_req = 1; fetch_addr = 32'h200;
        wait (s_busy);
        @(negedge clk); fetch_req = 0; flush = 1;
        @(negedge clk); flush = 0;
        wait (done_count == d + 1);
        repeat (2) @(negedge clk);
        model_clear();
        do_fetch(32'h200, 1'b0, "R8");

        // Error response on one beat of a refill.
        err_en = 1; err_line = 32'h300;
        d = done_count;
        @(negedge clk); fetch_req = 1; fetch_addr = 32'h304;
        wait (done_count == d + 1);
        fetch_req = 0;
        @(negedge clk); #1;
        chk(fill_error === 1'b1, "R7", "error flag set", 32'(fill_error), 1);
        err_en = 0;
        do_fetch(32'h304, 1'b0, "R7");
        chk(fill_error === 1'b1, "R7", "error flag sticky", 32'(fill_error), 1);

        // Random fetch mix against the reference model.
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a;
            a = ($urandom % 512) * 4;
            if ($urandom % 20 == 0) pulse_flush();
            else do_fetch(a, model_hit(a), "R5");
            if ($urandom % 4 == 0) repeat ($urandom % 3) @(negedge clk);
        end

        chk(viol_r3 == 0, "R3", "read address shape", 32'(viol_r3), 0);
        chk(viol_r4 == 0, "R4", "address hold", 32'(viol_r4), 0);
        chk(viol_r10 == 0, "R10", "single burst", 32'(viol_r10), 0);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule